// File: doc/BRIEF.md
# Wait-State AHB-Lite Word Store

This block is an AHB-Lite slave that holds a small bank of 32-bit words in flip-flops. A transfer's control (direction, size, word index, byte offset) is registered at the end of its address phase. The access itself happens in the data phase that follows. Write data is taken from the bus when the data phase completes. Read data is driven from the stored word during the read's data phase.

A parameter sets a fixed number of stall cycles for every accepted transfer. During those cycles the slave drives its ready output low. A wait count of zero gives single-cycle data phases. In that case an address phase can overlap the previous data phase, so a read placed right behind a write to the same word returns the new value.

Byte and halfword writes change only the addressed byte lanes. Bursts are not treated specially: each SEQ beat is a separate single access. The response is always OKAY.

Top module: `ahb_wait_mem`

## Requirements
- R1: After reset, hreadyout is 1, hresp is 0, hrdata is 0, and every stored word reads as zero.
- R2: htrans 2'b00 (IDLE) and 2'b01 (BUSY) start no access: the stored data is unchanged and no wait cycle follows. 2'b10 (NONSEQ) and 2'b11 (SEQ) each start one access.
- R3: A transfer is accepted only in a cycle where both hsel and hready are 1. A NONSEQ write presented with either of them at 0 changes nothing.
- R4: After an accepted transfer, hreadyout is 0 for exactly WAIT_CYCLES cycles of the data phase and is then 1 for the completing cycle. The captured control stays fixed while hreadyout is 0.
- R5: With WAIT_CYCLES = 0, every data phase completes in its first cycle (hreadyout stays 1).
- R6: Write data is sampled only at the completing cycle of the data phase. Values on hwdata during wait cycles have no effect, and the store changes only on a completing write.
- R7: hsize 3'b000 (byte) writes only the byte lane given by haddr[1:0]: lane n holds bits 8n+7:8n.
- R8: hsize 3'b001 (halfword) writes lanes 1:0 when haddr[1] is 0 and lanes 3:2 when haddr[1] is 1. hsize 3'b010 (word) writes all four lanes.
- R9: In the completing cycle of a read data phase, hrdata carries the whole addressed word. Outside a read data phase, hrdata is 0.
- R10: hresp is 0 in every cycle.
- R11: When the ready output is high in the completing cycle, a new address phase is accepted in that same cycle. A read that follows directly after a write to the same word returns the written data.
- R12: The word index is haddr[IDX_W+1:2], with IDX_W = log2(DEPTH). Addresses beyond DEPTH words wrap modulo DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | Slave select from the address decoder |
| haddr | input | ADDR_W | Byte address of the transfer |
| htrans | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| hwrite | input | 1 | 1 for write, 0 for read |
| hsize | input | 3 | Transfer size: byte, halfword, word |
| hwdata | input | 32 | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready; previous transfer done |
| hreadyout | output | 1 | This slave's ready; 0 stalls the data phase |
| hresp | output | 1 | Response, always OKAY (0) |
| hrdata | output | 32 | Read data in the read data phase |

## Verification
An accepted transfer registers its control at the next rising edge. Its completing cycle then comes WAIT_CYCLES cycles later. In that cycle the bench samples hrdata and presents the real hwdata, and it supplies deliberately wrong hwdata during each wait cycle before that. The bench counts the low-ready cycles at each falling edge rather than assuming them.

A write lands in the store at the completing edge. Its effect is checked by a later read, whose data is sampled on the falling edge inside that read's completing cycle. On the zero-wait instance, the overlapped write-then-read checks the read data one cycle after the read's address phase.

// File: rtl/ahbm_pkg.sv
package ahbm_pkg;

    localparam int BUS_W  = 32;
    localparam int LANES  = BUS_W / 8;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        TR_IDLE = 2'b00,
        TR_BUSY = 2'b01,
        TR_NSEQ = 2'b10,
        TR_SEQ  = 2'b11
    } trans_e;

    localparam logic [2:0] SZ_BYTE = 3'b000;
    localparam logic [2:0] SZ_HALF = 3'b001;
    localparam logic [2:0] SZ_WORD = 3'b010;

endpackage

// File: rtl/ahbm_phase_ctrl.sv
module ahbm_phase_ctrl
    import ahbm_pkg::*;
#(
    parameter int IDX_W       = 4,
    parameter int WAIT_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsel,
    input  logic             hready,
    input  logic [1:0]       htrans,
    input  logic             hwrite,
    input  logic [2:0]       hsize,
    input  logic [IDX_W-1:0] a_idx,
    input  logic [OFF_W-1:0] a_off,
    output logic             hreadyout,
    output logic             dp_read,
    output logic             dp_commit,
    output logic [IDX_W-1:0] dp_idx,
    output logic [2:0]       dp_size,
    output logic [OFF_W-1:0] dp_off
);

    localparam int WAIT_W = (WAIT_CYCLES < 1) ? 1 : $clog2(WAIT_CYCLES + 1);
    localparam logic [WAIT_W-1:0] WAIT_LOAD = WAIT_W'(WAIT_CYCLES);

    typedef struct packed {
        logic              active;
        logic              write;
        logic [2:0]        size;
        logic [OFF_W-1:0]  off;
        logic [IDX_W-1:0]  idx;
        logic [WAIT_W-1:0] cnt;
    } phase_t;

    phase_t st_d, st_q;
    logic   stall;
    logic   accept;

    always_comb begin
        st_d   = st_q;
        stall  = st_q.active && (st_q.cnt != '0);
        accept = hsel && hready &&
                 ((htrans == TR_NSEQ) || (htrans == TR_SEQ));
        if (stall) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else if (hready) begin
            st_d.active = accept;
            if (accept) begin
                st_d.write = hwrite;
                st_d.size  = hsize;
                st_d.off   = a_off;
                st_d.idx   = a_idx;
                st_d.cnt   = WAIT_LOAD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hreadyout = !stall;
    assign dp_read   = st_q.active && !st_q.write;
    assign dp_commit = st_q.active && st_q.write && !stall && hready;
    assign dp_idx    = st_q.idx;
    assign dp_size   = st_q.size;
    assign dp_off    = st_q.off;

    // R2: IDLE and BUSY never open a data phase
    assert_idle_busy_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hreadyout && hready && ((htrans == TR_IDLE) || (htrans == TR_BUSY)))
        |=> !st_q.active);

    // R3: without select and ready nothing is captured from an idle state
    assert_capture_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && !(hsel && hready)) |=> !st_q.active);

    // R4: first data-phase cycle stalls exactly when waits are configured
    assert_wait_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hreadyout && hready && hsel && htrans[1])
        |=> (hreadyout == (WAIT_CYCLES == 0)));

    // R4: captured control is held while stalled
    assert_hold_ctrl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !hreadyout |=> ($stable(st_q.idx) && $stable(st_q.write) &&
                        $stable(st_q.size) && $stable(st_q.off)));

endmodule

// File: rtl/ahbm_lane_strobe.sv
module ahbm_lane_strobe
    import ahbm_pkg::*;
(
    input  logic [2:0]       size,
    input  logic [OFF_W-1:0] off,
    output logic [LANES-1:0] strb
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE_ID = OFF_W'(l);
        assign strb[l] = (size == SZ_BYTE) ? (off == LANE_ID) :
                         (size == SZ_HALF) ? ((off >> 1) == (LANE_ID >> 1)) :
                                             1'b1;
    end

endmodule

// File: rtl/ahbm_word_store.sv
module ahbm_word_store
    import ahbm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [LANES-1:0] strb,
    input  logic [IDX_W-1:0] idx,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata
);

    logic [DEPTH-1:0][BUS_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (strb[l]) begin
                    mem_d[idx][8*l +: 8] = wdata[8*l +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[idx];

    // R6: the store only changes on a completing write
    assert_quiet_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mem_q));

endmodule

// File: rtl/ahb_wait_mem.sv
module ahb_wait_mem
    import ahbm_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DEPTH       = 16,
    parameter int WAIT_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [BUS_W-1:0]  hwdata,
    input  logic              hready,
    output logic              hreadyout,
    output logic              hresp,
    output logic [BUS_W-1:0]  hrdata
);

    localparam int IDX_W = (DEPTH < 2) ? 1 : $clog2(DEPTH);

    logic [IDX_W-1:0] a_idx;
    logic [OFF_W-1:0] a_off;
    logic             dp_read;
    logic             dp_commit;
    logic [IDX_W-1:0] dp_idx;
    logic [2:0]       dp_size;
    logic [OFF_W-1:0] dp_off;
    logic [LANES-1:0] strb;
    logic [BUS_W-1:0] word;

    assign a_idx = IDX_W'((haddr >> OFF_W) % DEPTH);
    assign a_off = haddr[OFF_W-1:0];

    ahbm_phase_ctrl #(
        .IDX_W       (IDX_W),
        .WAIT_CYCLES (WAIT_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsel      (hsel),
        .hready    (hready),
        .htrans    (htrans),
        .hwrite    (hwrite),
        .hsize     (hsize),
        .a_idx     (a_idx),
        .a_off     (a_off),
        .hreadyout (hreadyout),
        .dp_read   (dp_read),
        .dp_commit (dp_commit),
        .dp_idx    (dp_idx),
        .dp_size   (dp_size),
        .dp_off    (dp_off)
    );

    ahbm_lane_strobe u_strb (
        .size (dp_size),
        .off  (dp_off),
        .strb (strb)
    );

    ahbm_word_store #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (dp_commit),
        .strb  (strb),
        .idx   (dp_idx),
        .wdata (hwdata),
        .rdata (word)
    );

    assign hrdata = dp_read ? word : '0;
    assign hresp  = 1'b0;

    // R7: a byte write touches exactly one lane
    assert_byte_one_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_commit && (dp_size == SZ_BYTE)) |-> ($countones(strb) == 1));

    // R8: a halfword write touches exactly two lanes
    assert_half_two_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_commit && (dp_size == SZ_HALF)) |-> ($countones(strb) == 2));

    // R4: the store never changes while the data phase is stalled
    assert_no_write_in_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !hreadyout |-> !dp_commit);

endmodule

// File: tb/sim_ahb_wait_mem.sv
module sim_ahb_wait_mem;
    import ahbm_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic        s0, s1, rdy1_in;
    logic [31:0] addr, wdata;
    logic [1:0]  trans;
    logic        wr;
    logic [2:0]  size;
    logic        rdy0, resp0, rdy1, resp1;
    logic [31:0] rd0, rd1;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [31:0] model [16];

    ahb_wait_mem #(.ADDR_W(32), .DEPTH(16), .WAIT_CYCLES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .hsel(s0), .haddr(addr), .htrans(trans),
        .hwrite(wr), .hsize(size), .hwdata(wdata), .hready(rdy0),
        .hreadyout(rdy0), .hresp(resp0), .hrdata(rd0));

    ahb_wait_mem #(.ADDR_W(32), .DEPTH(16), .WAIT_CYCLES(0)) u1 (
        .clk(clk), .rst_n(rst_n), .hsel(s1), .haddr(addr), .htrans(trans),
        .hwrite(wr), .hsize(size), .hwdata(wdata), .hready(rdy1_in),
        .hreadyout(rdy1), .hresp(resp1), .hrdata(rd1));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [2:0] sz,
                                          input logic [1:0] off, input logic [31:0] d);
        logic [31:0] r = old;
        for (int l = 0; l < 4; l++) begin
            bit en = (sz == 3'b000) ? (l == int'(off)) :
                     (sz == 3'b001) ? ((l / 2) == int'(off[1])) : 1'b1;
            if (en) r[8*l +: 8] = d[8*l +: 8];
        end
        return r;
    endfunction

    task automatic xfer0(input logic [1:0] tr, input logic w, input logic [2:0] sz,
                         input logic [31:0] a, input logic [31:0] d,
                         output logic [31:0] rd, output int waits);
        @(negedge clk);
        s0 = 1'b1; addr = a; trans = tr; wr = w; size = sz; wdata = 32'h0BAD_0BAD;
        @(negedge clk);
        s0 = 1'b0; trans = TR_IDLE; waits = 0;
        while (rdy0 !== 1'b1) begin
            waits++;
            wdata = ~d;
            @(negedge clk);
        end
        wdata = d;
        rd = rd0;
        chk("R10 response okay", {31'b0, resp0}, 32'h0);
    endtask

    task automatic xfer1(input logic w, input logic [2:0] sz, input logic [31:0] a,
                         input logic [31:0] d, output logic [31:0] rd, output int waits);
        @(negedge clk);
        s1 = 1'b1; addr = a; trans = TR_NSEQ; wr = w; size = sz; rdy1_in = 1'b1;
        @(negedge clk);
        s1 = 1'b0; trans = TR_IDLE; waits = 0;
        while (rdy1 !== 1'b1) begin
            waits++;
            @(negedge clk);
        end
        wdata = d;
        rd = rd1;
    endtask

    task automatic wr0(input logic [1:0] tr, input logic [2:0] sz, input logic [31:0] a,
                       input logic [31:0] d, input string req);
        logic [31:0] rd;
        int waits;
        int ix = int'((a >> 2) % 16);
        xfer0(tr, 1'b1, sz, a, d, rd, waits);
        model[ix] = merge(model[ix], sz, a[1:0], d);
        chk({req, " write wait count"}, waits, 2);
        chk("R9 hrdata zero in write phase", rd, 32'h0);
    endtask

    task automatic rd0_chk(input logic [31:0] a, input string req);
        logic [31:0] rd;
        int waits;
        xfer0(TR_NSEQ, 1'b0, SZ_WORD, a, 32'h0, rd, waits);
        chk({req, " read data"}, rd, model[int'((a >> 2) % 16)]);
        chk("R4 read wait count", waits, 2);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 hreadyout after reset", {31'b0, rdy0}, 32'h1);
        chk("R1 hresp after reset", {31'b0, resp0}, 32'h0);
        chk("R1 hrdata after reset", rd0, 32'h0);
        rd0_chk(32'h14, "R1");
    endtask

    task automatic t_word();
        wr0(TR_NSEQ, SZ_WORD, 32'h08, 32'h1234_5678, "R4");
        rd0_chk(32'h08, "R6 R9");
        chk("R9 word value", model[2], 32'h1234_5678);
        wr0(TR_SEQ, SZ_WORD, 32'h0C, 32'hA5A5_0F0F, "R2 SEQ");
        rd0_chk(32'h0C, "R2 SEQ");
    endtask

    task automatic t_bytes();
        wr0(TR_NSEQ, SZ_BYTE, 32'h10, 32'h0000_0011, "R7");
        wr0(TR_NSEQ, SZ_BYTE, 32'h11, 32'h0000_2200, "R7");
        wr0(TR_NSEQ, SZ_BYTE, 32'h12, 32'h0033_0000, "R7");
        wr0(TR_NSEQ, SZ_BYTE, 32'h13, 32'h4400_0000, "R7");
        rd0_chk(32'h10, "R7");
        chk("R7 byte lanes assembled", model[4], 32'h4433_2211);
        wr0(TR_NSEQ, SZ_WORD, 32'h20, 32'hFFFF_FFFF, "R7");
        wr0(TR_NSEQ, SZ_BYTE, 32'h21, 32'h5555_AB55, "R7");
        rd0_chk(32'h20, "R7");
        chk("R7 single lane merge", model[8], 32'hFFFF_ABFF);
    endtask

    task automatic t_half();
        wr0(TR_NSEQ, SZ_HALF, 32'h22, 32'h5A5A_1111, "R8");
        rd0_chk(32'h20, "R8");
        chk("R8 upper half", model[8], 32'h5A5A_ABFF);
        wr0(TR_NSEQ, SZ_HALF, 32'h20, 32'h9999_C3C3, "R8");
        rd0_chk(32'h20, "R8");
        chk("R8 lower half", model[8], 32'h5A5A_C3C3);
    endtask

    task automatic t_idle_busy();
        @(negedge clk);
        s0 = 1'b1; addr = 32'h08; trans = TR_IDLE; wr = 1'b1; size = SZ_WORD;
        @(negedge clk);
        chk("R2 no wait after IDLE", {31'b0, rdy0}, 32'h1);
        wdata = 32'hFFFF_FFFF; trans = TR_BUSY;
        @(negedge clk);
        chk("R2 no wait after BUSY", {31'b0, rdy0}, 32'h1);
        s0 = 1'b0; trans = TR_IDLE; wdata = 32'hEEEE_EEEE;
        rd0_chk(32'h08, "R2 IDLE BUSY ignored");
    endtask

    task automatic t_wrap();
        wr0(TR_NSEQ, SZ_WORD, 32'h44, 32'hBEEF_0001, "R12");
        rd0_chk(32'h04, "R12 wrap");
        chk("R12 wrapped index", model[1], 32'hBEEF_0001);
    endtask

    task automatic t_gate_u1();
        logic [31:0] rd;
        int waits;
        @(negedge clk);
        s1 = 1'b0; rdy1_in = 1'b1; addr = 32'h04; trans = TR_NSEQ; wr = 1'b1; size = SZ_WORD;
        @(negedge clk);
        trans = TR_IDLE; wdata = 32'h1111_1111;
        @(negedge clk);
        s1 = 1'b1; rdy1_in = 1'b0; trans = TR_NSEQ; wr = 1'b1;
        @(negedge clk);
        s1 = 1'b0; rdy1_in = 1'b1; trans = TR_IDLE; wdata = 32'h2222_2222;
        chk("R3 no stall when not captured", {31'b0, rdy1}, 32'h1);
        xfer1(1'b0, SZ_WORD, 32'h04, 32'h0, rd, waits);
        chk("R3 unselected or unready write ignored", rd, 32'h0);
    endtask

    task automatic t_zero_wait_u1();
        logic [31:0] rd;
        int waits;
        xfer1(1'b1, SZ_WORD, 32'h18, 32'h7654_3210, rd, waits);
        chk("R5 zero-wait write", waits, 0);
        xfer1(1'b0, SZ_WORD, 32'h18, 32'h0, rd, waits);
        chk("R5 zero-wait read", waits, 0);
        chk("R5 zero-wait read data", rd, 32'h7654_3210);
    endtask

    task automatic t_pipe_u1();
        @(negedge clk);
        s1 = 1'b1; rdy1_in = 1'b1; addr = 32'h0C; trans = TR_NSEQ; wr = 1'b1; size = SZ_WORD;
        @(negedge clk);
        chk("R11 ready in write data phase", {31'b0, rdy1}, 32'h1);
        wdata = 32'hCAFE_F00D; wr = 1'b0;
        @(negedge clk);
        s1 = 1'b0; trans = TR_IDLE;
        chk("R11 read behind write", rd1, 32'hCAFE_F00D);
        chk("R10 zero-wait response okay", {31'b0, resp1}, 32'h0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 32'h0;
        rst_n = 1'b0; s0 = 1'b0; s1 = 1'b0; rdy1_in = 1'b1;
        addr = '0; wdata = '0; trans = TR_IDLE; wr = 1'b0; size = SZ_WORD;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_word();
        t_bytes();
        t_half();
        t_idle_busy();
        t_wrap();
        t_gate_u1();
        t_zero_wait_u1();
        t_pipe_u1();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule